// File: doc/BRIEF.md
# Four-Lane Serial Datalink Aggregator

This block gathers the bit streams of four converters that each report their result as a pair of return-to-zero comparator rails. For each lane it rebuilds a bit clock and a data bit from the two rails, and moves every bit into the core clock domain through a small dual-clock FIFO. A start gate holds reading back until all four FIFOs have held data for a few core cycles. Once reading starts, all four lanes are read together, one bit per lane per cycle, which forms a 4-bit word.

Two consecutive words make a byte. Each byte is 8b/10b encoded with running disparity. The block emits one 10-bit symbol every two core cycles to a 10:1 serializer that sits outside the block. When no stream is active, the output carries comma symbols. A built-in 16-bit PRBS source can take the place of the FIFO outputs for bit-error testing of the link.

Top module: `dl_aggregator`

## Requirements
- R1: A pulse on a lane's positive rail is recovered as a 1 and a pulse on its negative rail as a 0. The two rails are never high together and return to zero between bits.
- R2: Each lane buffers its recovered bits in its own dual-clock FIFO of 2^FIFO_AW entries (16 by default). When bits arrive at one per core cycle, a FIFO never holds more entries than its depth.
- R3: Reading starts only after all four FIFOs have been non-empty for START_DLY (5) consecutive core cycles and each holds at least two entries. Reads happen in both cycles of a symbol slot, and all lanes are read together. A FIFO is never read while it is empty. A continuous stream is delivered without comma symbols in the middle, and every bit written is delivered.
- R4: Within a word, lane l supplies bit l. The first word of a slot becomes bits 3:0 of the byte and the second word becomes bits 7:4.
- R5: Each byte HGFEDCBA is sent as its standard 8b/10b data code. sym[9:0] carries the code bits in the order a,b,c,d,e,i,f,g,h,j, with a in bit 9, and the serializer sends bit 9 first.
- R6: Running disparity is negative after reset. Each symbol has 4, 5 or 6 ones. A symbol with 6 ones is sent only when the disparity is negative, and one with 4 ones only when it is positive. The disparity flips exactly when a symbol's ones count differs from 5.
- R7: sym_stb is low during reset. After reset, sym_stb is high in exactly one of every two core cycles, and sym changes only in the cycle where sym_stb is high.
- R8: In a slot with no active source, the symbol is the K28.5 comma that matches the current disparity: 0011111010 when negative and 1100000101 when positive. The first symbol after reset is 0011111010.
- R9: prbs_en is sampled only at slot boundaries. While it is set, the PRBS supplies every word and the FIFOs are not read. The generator uses x^16+x^14+x^13+x^11+1 and starts from the seed 16'hACE1. Each step shifts the state left and puts s15^s13^s12^s10 into bit 0. A word holds four new bits, with the first one generated in bit 0. The state advances only while it supplies words, so each use resumes where the last one stopped, and the state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one bit per lane is read each cycle |
| rst | input | 1 | Active-high reset, synchronous in the core domain |
| cmp_pos | input | 4 | Positive comparator rail of each lane (return-to-zero) |
| cmp_neg | input | 4 | Negative comparator rail of each lane (return-to-zero) |
| prbs_en | input | 1 | Selects the PRBS source in place of the FIFOs |
| sym | output | 10 | Current 8b/10b symbol for the serializer, bit 9 sent first |
| sym_stb | output | 1 | High for one cycle when a new symbol is loaded into sym |

## Verification
A single active lane with the other three silent (byte 0x11) shows whether each lane lands on its own bit and whether the two words of a byte are in the right order. A per-lane counting pattern puts a different bit sequence on every lane, and a long run of zeros followed by ones exercises the most unbalanced codes and the disparity bookkeeping. A pseudo-random stream covers the full code table. Two separate PRBS runs show whether the generator's sequence is correct and whether it resumes where the first run left off rather than restarting. The idle periods between streams check that the comma alternates with the disparity and that the start gate leaves no words half-delivered.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int LANES = 4;
  localparam int SYM_W = 10;
  localparam logic [SYM_W-1:0] K285_NEG = 10'b0011111010;
  localparam logic [SYM_W-1:0] K285_POS = 10'b1100000101;
  typedef enum logic [1:0] {SRC_IDLE, SRC_FIFO, SRC_PRBS} src_t;
endpackage

// File: rtl/dl_rz_recover.sv
// Rebuilds bit clock and bit value from a return-to-zero rail pair.
module dl_rz_recover (
  input  logic rail_p,
  input  logic rail_n,
  output logic bit_clk,
  output logic bit_val
);
  assign bit_clk = rail_p | rail_n;

  // Constant-1 flop: a positive pulse sets it, a negative pulse clears it.
  always_ff @(posedge bit_clk or posedge rail_n) begin
    if (rail_n) bit_val <= 1'b0;
    else        bit_val <= 1'b1;
  end
endmodule

// File: rtl/dl_cdc_fifo.sv
// One-bit dual-clock FIFO. It writes on the falling edge of the recovered
// clock and reads in the core domain. Pointers cross in Gray code.
module dl_cdc_fifo #(
  parameter int AW = 4
) (
  input  logic        rst,
  input  logic        wclk,
  input  logic        wdata,
  input  logic        clk,
  input  logic        rd_en,
  output logic        rdata,
  output logic [AW:0] occ
);
  localparam int DEPTH = 1 << AW;

  logic          mem [DEPTH];
  logic [AW:0]   wbin, wgray, sync1, sync2, rbin;

  function automatic logic [AW:0] to_bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(negedge wclk) mem[wbin[AW-1:0]] <= wdata;

  always_ff @(negedge wclk or posedge rst) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin + 1'b1;
      wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      rbin  <= '0;
    end else begin
      sync1 <= wgray;
      sync2 <= sync1;
      if (rd_en) rbin <= rbin + 1'b1;
    end
  end

  assign occ   = to_bin(sync2) - rbin;
  assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/dl_prbs16.sv
// 16-bit Fibonacci LFSR that produces four bits per advance.
module dl_prbs16 #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  output logic [3:0]  word,
  output logic [15:0] state
);
  logic [15:0] nxt;

  always_comb begin
    nxt = state;
    for (int i = 0; i < 4; i++) begin
      word[i] = nxt[15] ^ nxt[13] ^ nxt[12] ^ nxt[10];
      nxt     = {nxt[14:0], word[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= nxt;
  end
endmodule

// File: rtl/dl_enc8b10b.sv
// Registered 8b/10b encoder with running disparity (rd_pos=1 means positive).
module dl_enc8b10b
  import dl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             is_data,
  input  logic [7:0]       din,
  output logic [SYM_W-1:0] sym,
  output logic             sym_stb
);
  logic       rd_pos, rd_mid, rd_end, alt7;
  logic [4:0] x;
  logic [2:0] y;
  logic [5:0] c6, s6;
  logic [3:0] c4, s4;

  // Negative-disparity 5b/6b codes, abcdei with a in bit 5.
  function automatic logic [5:0] code6(input logic [4:0] v);
    case (v)
      5'd0:  code6 = 6'b100111;  5'd1:  code6 = 6'b011101;
      5'd2:  code6 = 6'b101101;  5'd3:  code6 = 6'b110001;
      5'd4:  code6 = 6'b110101;  5'd5:  code6 = 6'b101001;
      5'd6:  code6 = 6'b011001;  5'd7:  code6 = 6'b111000;
      5'd8:  code6 = 6'b111001;  5'd9:  code6 = 6'b100101;
      5'd10: code6 = 6'b010101;  5'd11: code6 = 6'b110100;
      5'd12: code6 = 6'b001101;  5'd13: code6 = 6'b101100;
      5'd14: code6 = 6'b011100;  5'd15: code6 = 6'b010111;
      5'd16: code6 = 6'b011011;  5'd17: code6 = 6'b100011;
      5'd18: code6 = 6'b010011;  5'd19: code6 = 6'b110010;
      5'd20: code6 = 6'b001011;  5'd21: code6 = 6'b101010;
      5'd22: code6 = 6'b011010;  5'd23: code6 = 6'b111010;
      5'd24: code6 = 6'b110011;  5'd25: code6 = 6'b100110;
      5'd26: code6 = 6'b010110;  5'd27: code6 = 6'b110110;
      5'd28: code6 = 6'b001110;  5'd29: code6 = 6'b101110;
      5'd30: code6 = 6'b011110;  default: code6 = 6'b101011;
    endcase
  endfunction

  // Negative-disparity 3b/4b codes, fghj with f in bit 3.
  function automatic logic [3:0] code4(input logic [2:0] v);
    case (v)
      3'd0: code4 = 4'b1011;  3'd1: code4 = 4'b1001;
      3'd2: code4 = 4'b0101;  3'd3: code4 = 4'b1100;
      3'd4: code4 = 4'b1101;  3'd5: code4 = 4'b1010;
      3'd6: code4 = 4'b0110;  default: code4 = 4'b1110;
    endcase
  endfunction

  always_comb begin
    x      = din[4:0];
    y      = din[7:5];
    c6     = code6(x);
    s6     = (rd_pos && ($countones(c6) != 3 || x == 5'd7)) ? ~c6 : c6;
    rd_mid = rd_pos ^ ($countones(c6) != 3);
    alt7   = (y == 3'd7) &&
             ((!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
              ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    c4     = alt7 ? 4'b0111 : code4(y);
    s4     = (rd_mid && ($countones(c4) != 2 || y == 3'd3)) ? ~c4 : c4;
    rd_end = rd_mid ^ ($countones(c4) != 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym     <= '0;
      sym_stb <= 1'b0;
      rd_pos  <= 1'b0;
    end else begin
      sym_stb <= load;
      if (load) begin
        if (is_data) begin
          sym    <= {s6, s4};
          rd_pos <= rd_end;
        end else begin
          sym    <= rd_pos ? K285_POS : K285_NEG;
          rd_pos <= ~rd_pos;
        end
      end
    end
  end
endmodule

// File: rtl/dl_aggregator.sv
module dl_aggregator
  import dl_pkg::*;
#(
  parameter int          FIFO_AW   = 4,
  parameter int          START_DLY = 5,
  parameter logic [15:0] PRBS_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] cmp_pos,
  input  logic [LANES-1:0] cmp_neg,
  input  logic             prbs_en,
  output logic [SYM_W-1:0] sym,
  output logic             sym_stb
);
  localparam int OW = FIFO_AW + 1;
  localparam int DW = $clog2(START_DLY + 1);
  localparam logic [OW-1:0] TWO  = OW'(2);
  localparam logic [DW-1:0] DMAX = DW'(START_DLY);

  logic [OW*LANES-1:0] occ_flat;
  logic [LANES-1:0]    fifo_bit;
  logic                rd_fifo, prbs_adv, ph, all_live, all_two, ready;
  logic [DW-1:0]       dly;
  logic [3:0]          word, prbs_word, lo_q;
  logic [15:0]         prbs_state;
  src_t                cur_src, mode_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic          bclk, bval;
    logic [OW-1:0] occ_l;
    dl_rz_recover u_rec (
      .rail_p(cmp_pos[l]), .rail_n(cmp_neg[l]), .bit_clk(bclk), .bit_val(bval)
    );
    dl_cdc_fifo #(.AW(FIFO_AW)) u_fifo (
      .rst(rst), .wclk(bclk), .wdata(bval), .clk(clk), .rd_en(rd_fifo),
      .rdata(fifo_bit[l]), .occ(occ_l)
    );
    assign occ_flat[l*OW +: OW] = occ_l;
  end

  always_comb begin
    all_live = 1'b1;
    all_two  = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (occ_flat[l*OW +: OW] == '0) all_live = 1'b0;
      if (occ_flat[l*OW +: OW] <  TWO) all_two = 1'b0;
    end
  end

  assign ready = (dly == DMAX) && all_two;

  // Source is chosen at the first cycle of each symbol slot and held for both.
  always_comb begin
    if (!ph) begin
      if (prbs_en)    cur_src = SRC_PRBS;
      else if (ready) cur_src = SRC_FIFO;
      else            cur_src = SRC_IDLE;
    end else begin
      cur_src = mode_q;
    end
  end

  assign rd_fifo  = (cur_src == SRC_FIFO);
  assign prbs_adv = (cur_src == SRC_PRBS);
  assign word     = prbs_adv ? prbs_word : fifo_bit;

  dl_prbs16 #(.SEED(PRBS_SEED)) u_prbs (
    .clk(clk), .rst(rst), .adv(prbs_adv), .word(prbs_word), .state(prbs_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= 1'b0;
      mode_q <= SRC_IDLE;
      lo_q   <= '0;
      dly    <= '0;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        mode_q <= cur_src;
        lo_q   <= word;
      end
      if (!all_live)        dly <= '0;
      else if (dly != DMAX) dly <= dly + 1'b1;
    end
  end

  dl_enc8b10b u_enc (
    .clk(clk), .rst(rst), .load(ph), .is_data(mode_q != SRC_IDLE),
    .din({word, lo_q}), .sym(sym), .sym_stb(sym_stb)
  );
endmodule

// File: rtl/dl_agg_chk.sv
module dl_agg_chk #(
  parameter int AW        = 4,
  parameter int START_DLY = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic [9:0]           sym,
  input logic                 sym_stb,
  input logic                 rd_fifo,
  input logic [(AW+1)*4-1:0]  occ_flat,
  input logic [15:0]          prbs_state
);
  localparam int OW = AW + 1;
  localparam int DW = $clog2(START_DLY + 1);

  logic          over, empty_any, rd_c;
  logic [DW-1:0] live_cnt;

  always_comb begin
    over      = 1'b0;
    empty_any = 1'b0;
    for (int l = 0; l < 4; l++) begin
      if (int'(occ_flat[l*OW +: OW]) > (1 << AW)) over = 1'b1;
      if (occ_flat[l*OW +: OW] == '0) empty_any = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_c     <= 1'b0;
      live_cnt <= '0;
    end else begin
      if (sym_stb) rd_c <= rd_c ^ ($countones(sym) != 5);
      if (empty_any) live_cnt <= '0;
      else if (live_cnt != DW'(START_DLY)) live_cnt <= live_cnt + 1'b1;
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst) !over);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
    rd_fifo |-> !empty_any);
  a_r3_start_delay: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_fifo) |-> live_cnt == DW'(START_DLY));
  a_r6_sym_weight: assert property (@(posedge clk) disable iff (rst)
    sym_stb |-> ($countones(sym) >= 4 && $countones(sym) <= 6));
  a_r6_heavy_on_neg: assert property (@(posedge clk) disable iff (rst)
    (sym_stb && $countones(sym) == 6) |-> !rd_c);
  a_r6_light_on_pos: assert property (@(posedge clk) disable iff (rst)
    (sym_stb && $countones(sym) == 4) |-> rd_c);
  a_r7_stb_gap: assert property (@(posedge clk) disable iff (rst)
    sym_stb |=> !sym_stb);
  a_r7_stb_period: assert property (@(posedge clk) disable iff (rst)
    sym_stb |-> ##2 sym_stb);
  a_r7_sym_hold: assert property (@(posedge clk) disable iff (rst)
    !sym_stb |=> $stable(sym) || sym_stb);
  a_r9_prbs_nonzero: assert property (@(posedge clk) disable iff (rst)
    prbs_state != 16'h0000);
endmodule

bind dl_aggregator dl_agg_chk #(.AW(FIFO_AW), .START_DLY(START_DLY)) u_chk (
  .clk(clk), .rst(rst), .sym(sym), .sym_stb(sym_stb), .rd_fifo(rd_fifo),
  .occ_flat(occ_flat), .prbs_state(prbs_state)
);

// File: tb/test_dl_aggregator.sv
module test_dl_aggregator;
  localparam logic [9:0] K_NEG = 10'b0011111010;
  localparam logic [9:0] K_POS = 10'b1100000101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cmp_pos = '0;
  logic [3:0] cmp_neg = '0;
  logic       prbs_en = 1'b0;
  logic [9:0] sym;
  logic       sym_stb;

  int n_vec = 0, n_bad = 0, n_stb = 0, rx_data = 0;
  logic [9:0] first_sym [2];
  logic [7:0] exp_q [$];
  logic       rd_m = 1'b0;
  logic       streaming = 1'b0, seen_data = 1'b0, done = 1'b0;
  logic       lb [4][512];
  int         nb = 0;
  logic [3:0] pnib [2048];

  always #5 clk = ~clk;

  dl_aggregator i_dl_aggregator (
    .clk(clk), .rst(rst), .cmp_pos(cmp_pos), .cmp_neg(cmp_neg),
    .prbs_en(prbs_en), .sym(sym), .sym_stb(sym_stb)
  );

  task automatic check(input logic ok, input string req, input logic [9:0] act,
                       input logic [9:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Standard 8b/10b reference, output a..j with a in bit 9.
  function automatic logic [9:0] ref_enc(input logic [7:0] b, input logic rd);
    logic [5:0] t6; logic [3:0] t4; logic r;
    case (b[4:0])
      0: t6=6'b100111; 1: t6=6'b011101; 2: t6=6'b101101; 3: t6=6'b110001;
      4: t6=6'b110101; 5: t6=6'b101001; 6: t6=6'b011001; 7: t6=6'b111000;
      8: t6=6'b111001; 9: t6=6'b100101; 10: t6=6'b010101; 11: t6=6'b110100;
      12: t6=6'b001101; 13: t6=6'b101100; 14: t6=6'b011100; 15: t6=6'b010111;
      16: t6=6'b011011; 17: t6=6'b100011; 18: t6=6'b010011; 19: t6=6'b110010;
      20: t6=6'b001011; 21: t6=6'b101010; 22: t6=6'b011010; 23: t6=6'b111010;
      24: t6=6'b110011; 25: t6=6'b100110; 26: t6=6'b010110; 27: t6=6'b110110;
      28: t6=6'b001110; 29: t6=6'b101110; 30: t6=6'b011110; default: t6=6'b101011;
    endcase
    r = rd;
    if (r && ($countones(t6) != 3 || b[4:0] == 5'd7)) t6 = ~t6;
    if ($countones(t6) != 3) r = ~r;
    case (b[7:5])
      0: t4=4'b1011; 1: t4=4'b1001; 2: t4=4'b0101; 3: t4=4'b1100;
      4: t4=4'b1101; 5: t4=4'b1010; 6: t4=4'b0110; default: t4=4'b1110;
    endcase
    if (b[7:5] == 3'd7 &&
        ((!r && (b[4:0] == 17 || b[4:0] == 18 || b[4:0] == 20)) ||
         ( r && (b[4:0] == 11 || b[4:0] == 13 || b[4:0] == 14))))
      t4 = 4'b0111;
    if (r && ($countones(t4) != 2 || b[7:5] == 3'd3)) t4 = ~t4;
    return {t6, t4};
  endfunction

  // Monitor: pops the expected bytes and compares them with each symbol.
  always @(negedge clk) begin
    if (!rst && sym_stb) begin
      int ones;
      ones = $countones(sym);
      if (n_stb < 2) first_sym[n_stb] = sym;
      n_stb++;
      check(!((ones == 6 && rd_m) || (ones == 4 && !rd_m) || ones < 4 || ones > 6),
            "R6 disparity", sym, rd_m ? K_POS : K_NEG);
      if (sym == (rd_m ? K_POS : K_NEG)) begin
        if (streaming && seen_data && exp_q.size() > 0)
          check(1'b0, "R3 idle inside stream", sym, 10'h0);
      end else if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected data symbol", sym, rd_m ? K_POS : K_NEG);
      end else begin
        logic [9:0] e;
        e = ref_enc(exp_q.pop_front(), rd_m);
        check(sym == e, "R5/R4 data symbol", sym, e);
        seen_data = 1'b1;
        rx_data++;
      end
      rd_m = rd_m ^ (ones != 5);
    end
  end

  task automatic drive_lane(input int l);
    @(posedge clk);
    #(1 + 2 * l);
    for (int t = 0; t < nb; t++) begin
      if (lb[l][t]) cmp_pos[l] = 1'b1; else cmp_neg[l] = 1'b1;
      #4;
      cmp_pos[l] = 1'b0;
      cmp_neg[l] = 1'b0;
      #6;
    end
  endtask

  task automatic send_stream(input string tag);
    for (int t = 0; t + 1 < nb; t += 2) begin
      logic [3:0] n0, n1;
      for (int l = 0; l < 4; l++) begin
        n0[l] = lb[l][t];
        n1[l] = lb[l][t+1];
      end
      exp_q.push_back({n1, n0});
    end
    seen_data = 1'b0;
    streaming = 1'b1;
    fork
      drive_lane(0); drive_lane(1); drive_lane(2); drive_lane(3);
    join
    repeat (80) @(posedge clk);
    @(negedge clk);
    streaming = 1'b0;
    check(exp_q.size() == 0, {"R3 all bytes delivered ", tag},
          10'(exp_q.size()), 10'd0);
    exp_q.delete();
  endtask

  task automatic prbs_run(input int base, output int got);
    int start;
    for (int k = 0; k < 300; k++)
      exp_q.push_back({pnib[base + 2*k + 1], pnib[base + 2*k]});
    start = rx_data;
    seen_data = 1'b0;
    @(negedge clk);
    streaming = 1'b1;
    prbs_en = 1'b1;
    repeat (400) @(negedge clk);
    streaming = 1'b0;
    prbs_en = 1'b0;
    repeat (20) @(negedge clk);
    got = rx_data - start;
    check(got >= 190 && got <= 210, "R9 PRBS symbol count", 10'(got), 10'd200);
    exp_q.delete();
  endtask

  initial begin
    logic [15:0] s;
    int got1, got2;
    int unsigned lcg;
    s = 16'hACE1;
    for (int i = 0; i < 2048; i++) begin
      for (int j = 0; j < 4; j++) begin
        pnib[i][j] = s[15] ^ s[13] ^ s[12] ^ s[10];
        s = {s[14:0], pnib[i][j]};
      end
    end
    repeat (4) @(negedge clk);
    check(sym_stb == 1'b0, "R7 strobe low in reset", 10'(sym_stb), 10'd0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(first_sym[0] == K_NEG, "R8 first idle symbol negative", first_sym[0], K_NEG);
    check(first_sym[1] == K_POS, "R8 second idle symbol positive", first_sym[1], K_POS);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        hi += int'(sym_stb);
      end
      check(hi == 4, "R7 one strobe per two cycles", 10'(hi), 10'd4);
    end

    // R1 R4: only lane 0 carries ones, so every byte is 0x11.
    nb = 32;
    for (int t = 0; t < nb; t++) for (int l = 0; l < 4; l++) lb[l][t] = (l == 0);
    send_stream("single lane");

    // R4: per-lane counting pattern.
    nb = 64;
    for (int t = 0; t < nb; t++) for (int l = 0; l < 4; l++) lb[l][t] = t[l];
    send_stream("counting");

    // R6: long zero run then long one run.
    nb = 64;
    for (int t = 0; t < nb; t++) for (int l = 0; l < 4; l++) lb[l][t] = (t >= 32);
    send_stream("zeros then ones");

    // R5: pseudo-random bytes.
    nb = 400;
    lcg = 32'd12345;
    for (int t = 0; t < nb; t++) for (int l = 0; l < 4; l++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      lb[l][t] = lcg[16];
    end
    send_stream("random");

    // R9: two PRBS runs; the second resumes the sequence.
    prbs_run(0, got1);
    prbs_run(2 * got1, got2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule